// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a 10-bit successive-approximation converter. It drives the DAC code, the track/hold control, an active-low precharge for the comparator's output latch and a one-hot input-channel select. It reads back one comparator bit. The analog parts are outside the block: the DAC, the comparator, the gain stages and the reference selection.

A conversion begins when `start` is seen while the block is idle and enabled. The block first tracks the input for a set number of cycles, with the DAC parked at mid-scale. It then holds the input and resolves the code from the most significant bit down to the least significant bit. Each bit takes one comparison, and each comparison has three timed phases: precharge, settle and latch. At the end the result register loads, and `done` pulses for one cycle in the same clock.

Each time the block becomes enabled, it first runs a dummy conversion on its own. That conversion produces neither a result nor a `done` pulse.

States:

| State | Role |
|---|---|
| IDLE | Waiting for work. |
| SAMPLE | Tracking the input. |
| PRECH | Latch precharge. |
| SETTLE | DAC settling. |
| LATCH | Reading the comparator. |

Transitions:

| Transition | Condition |
|---|---|
| IDLE→SAMPLE | Enabled, and either a dummy is armed or `start` is high. |
| SAMPLE→PRECH | The sample count has elapsed; the bit index is loaded with the MSB. |
| PRECH→SETTLE | The precharge count has elapsed. |
| SETTLE→LATCH | The settle count has elapsed. |
| LATCH→PRECH | The latch count has elapsed and this was not the last bit; the bit index steps down. |
| LATCH→IDLE | The last bit has been decided. |
| any→IDLE | `enable` is low. |

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset the block has the following outputs, and it keeps them until enabled:
  - `busy`=0
  - `hold`=0
  - `prech_n`=1
  - `done`=0
  - `result`=0
  - `chan_sel`=0
  - `dac_code`=0x200
- R2: Whenever `hold` is 0 (tracking), `dac_code` equals the mid-scale code 0x200.
- R3: Each conversion makes exactly 10 comparisons.
  - Each comparison drives `prech_n` low for PRE_CYC cycles and then high for SETTLE_CYC+LATCH_CYC cycles before the comparator is read.
  - `hold` is 1 throughout all comparisons.
- R4: Bits are tried MSB first.
  - The trial code is the bits decided so far with the bit under test set.
  - A comparator value of 1 means the input is at or above the DAC. A 1 keeps the bit and a 0 clears it.
  - For any input code 0..1023, the result equals that code.
- R5: When `enable` goes from 0 to 1, a dummy conversion starts without `start`. It raises no `done` and leaves `result` unchanged.
- R6: While `busy`, `chan_sel` is the one-hot decode of the `chan_idx` captured when the conversion began (index 3 gives 0x08). While idle, `chan_sel` is 0.
- R7: A `start` that arrives while `busy` is ignored. No further conversion runs after the current one ends.
- R8: Deasserting `enable` returns the block to idle at the next clock edge, with no `done` and `result` unchanged. Re-enabling runs a new dummy conversion.
- R9: `done` is high for exactly one cycle, and `result` changes only in that cycle. During that cycle `busy` is 0 and a `start` is accepted.
- R10: From the clock edge that accepts `start` to the edge that raises `done` there are SAMPLE_CYC + 10·(PRE_CYC+SETTLE_CYC+LATCH_CYC) cycles. With the defaults this is 34, so `done` is visible after the 35th edge counted from the first edge that sees `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; 0 forces idle and arms a dummy conversion |
| start | input | 1 | Conversion request, sampled while idle |
| chan_idx | input | 3 | Binary index of the channel to convert |
| cmp_in | input | 1 | Comparator bit: 1 when the input is at or above the DAC level |
| dac_code | output | 10 | Code driven to the DAC |
| hold | output | 1 | 0 = track the input, 1 = hold it |
| prech_n | output | 1 | Active-low comparator latch precharge |
| chan_sel | output | 8 | One-hot input-channel select |
| busy | output | 1 | A conversion (real or dummy) is in progress |
| result | output | 10 | Last real conversion result |
| done | output | 1 | One-cycle pulse when `result` loads |

## Verification
Two functions can fall in the same cycle: the `done` pulse of one conversion and the acceptance of the next `start`. The bench provokes this by holding `start` high across several conversions. It then judges that in each `done` cycle `busy` is low, that `busy` rises at the very next edge, and that every chained result still equals the modelled input. A second collision, `enable` dropping in the middle of a conversion, is judged by the absence of `done` and an unchanged `result`.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_PRECH  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_LATCH  = 3'd4
    } sar_state_t;
endpackage

// File: rtl/sar_seq_fsm.sv
`timescale 1ns/1ps
module sar_seq_fsm
    import sar_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int SAMPLE_CYC = 4,
    parameter int PRE_CYC    = 1,
    parameter int SETTLE_CYC = 1,
    parameter int LATCH_CYC  = 1,
    parameter int IDX_W      = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    output sar_state_t       state,
    output logic [IDX_W-1:0] bit_idx,
    output logic             accept,
    output logic             decide,
    output logic             finish_real
);
    localparam int MAX_AB = (SAMPLE_CYC > PRE_CYC) ? SAMPLE_CYC : PRE_CYC;
    localparam int MAX_CD = (SETTLE_CYC > LATCH_CYC) ? SETTLE_CYC : LATCH_CYC;
    localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W  = (MAX_C > 1) ? $clog2(MAX_C) : 1;
    localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(RES_W - 1);

    sar_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, limit;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             dummy_q, dummy_d;
    logic             arm_q, arm_d;
    logic             phase_last;

    // phase length of the current state
    always_comb begin
        unique case (state_q)
            ST_SAMPLE: limit = CNT_W'(SAMPLE_CYC - 1);
            ST_PRECH:  limit = CNT_W'(PRE_CYC - 1);
            ST_SETTLE: limit = CNT_W'(SETTLE_CYC - 1);
            ST_LATCH:  limit = CNT_W'(LATCH_CYC - 1);
            default:   limit = '0;
        endcase
    end

    assign phase_last = (cnt_q == limit);
    assign accept     = (state_q == ST_IDLE) && enable && (arm_q || start);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        dummy_d = dummy_q;
        arm_d   = arm_q;
        if (!enable) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            dummy_d = 1'b0;
            arm_d   = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_d = ST_SAMPLE;
                        cnt_d   = '0;
                        dummy_d = arm_q;
                        arm_d   = 1'b0;
                    end
                end
                ST_SAMPLE: begin
                    if (phase_last) begin
                        state_d = ST_PRECH;
                        cnt_d   = '0;
                        idx_d   = TOP_BIT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_PRECH: begin
                    if (phase_last) begin
                        state_d = ST_SETTLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (phase_last) begin
                        state_d = ST_LATCH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_LATCH: begin
                    if (phase_last) begin
                        cnt_d = '0;
                        if (idx_q == '0) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_PRECH;
                            idx_d   = idx_q - 1'b1;
                        end
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= TOP_BIT;
            dummy_q <= 1'b0;
            arm_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            dummy_q <= dummy_d;
            arm_q   <= arm_d;
        end
    end

    // outputs
    always_comb begin
        state       = state_q;
        bit_idx     = idx_q;
        decide      = enable && (state_q == ST_LATCH) && phase_last;
        finish_real = decide && (idx_q == '0) && !dummy_q;
    end

    assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == ST_IDLE);
    assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRECH || state_q == ST_SETTLE || state_q == ST_LATCH)
        |=> state_q != ST_SAMPLE);
    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAMPLE && state_d == ST_PRECH) |=> idx_q == TOP_BIT);
endmodule

// File: rtl/sar_approx_reg.sv
`timescale 1ns/1ps
module sar_approx_reg #(
    parameter int RES_W = 10,
    parameter int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             trial_en,
    input  logic             decide,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] resolved
);
    localparam logic [RES_W-1:0] MID = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic [RES_W-1:0] ONE = {{(RES_W-1){1'b0}}, 1'b1};

    logic [RES_W-1:0] acc_q, mask, trial;

    assign mask     = ONE << bit_idx;
    assign trial    = acc_q | mask;
    assign dac_code = trial_en ? trial : MID;
    assign resolved = cmp ? trial : (acc_q & ~mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (decide) begin
            acc_q <= resolved;
        end
    end

    assert_lower_bits_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trial_en |-> ((acc_q & ((mask << 1) - ONE)) == '0));
endmodule

// File: rtl/sar_chan_dec.sv
`timescale 1ns/1ps
module sar_chan_dec #(
    parameter int CH_N = 8,
    parameter int CH_W = $clog2(CH_N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [CH_W-1:0] idx,
    input  logic            active,
    output logic [CH_N-1:0] onehot
);
    logic [CH_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= '0;
        else if (capture) idx_q <= idx;
    end

    generate
        for (genvar g = 0; g < CH_N; g++) begin : g_sel
            assign onehot[g] = active && (idx_q == CH_W'(g));
        end
    endgenerate
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int CH_N       = 8,
    parameter int SAMPLE_CYC = 4,
    parameter int PRE_CYC    = 1,
    parameter int SETTLE_CYC = 1,
    parameter int LATCH_CYC  = 1,
    parameter int CH_W       = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [CH_W-1:0]  chan_idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic             hold,
    output logic             prech_n,
    output logic [CH_N-1:0]  chan_sel,
    output logic             busy,
    output logic [RES_W-1:0] result,
    output logic             done
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [RES_W-1:0] MID = {1'b1, {(RES_W-1){1'b0}}};

    sar_state_t       state;
    logic [IDX_W-1:0] bit_idx;
    logic             accept, decide, finish_real;
    logic [RES_W-1:0] resolved;
    logic [RES_W-1:0] result_q;
    logic             done_q;

    sar_seq_fsm #(
        .RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC), .PRE_CYC(PRE_CYC),
        .SETTLE_CYC(SETTLE_CYC), .LATCH_CYC(LATCH_CYC), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .state(state), .bit_idx(bit_idx), .accept(accept),
        .decide(decide), .finish_real(finish_real)
    );

    sar_approx_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .clear(accept), .trial_en(hold),
        .decide(decide), .bit_idx(bit_idx), .cmp(cmp_in),
        .dac_code(dac_code), .resolved(resolved)
    );

    sar_chan_dec #(.CH_N(CH_N), .CH_W(CH_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .capture(accept), .idx(chan_idx),
        .active(busy), .onehot(chan_sel)
    );

    always_comb begin
        busy    = (state != ST_IDLE);
        hold    = (state == ST_PRECH) || (state == ST_SETTLE) || (state == ST_LATCH);
        prech_n = (state != ST_PRECH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish_real;
            if (finish_real) result_q <= resolved;
        end
    end

    assign result = result_q;
    assign done   = done_q;

    assert_mid_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> dac_code == MID);
    assert_prech_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !prech_n |-> hold);
    assert_chan_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(chan_sel));
    assert_chan_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> chan_sel == '0);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;
    localparam int RES_W = 10, CH_N = 8, CH_W = 3;
    localparam int SAMPLE_CYC = 4, PRE_CYC = 1, SETTLE_CYC = 1, LATCH_CYC = 1;
    localparam int LAT = 1 + SAMPLE_CYC + RES_W * (PRE_CYC + SETTLE_CYC + LATCH_CYC);

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, start = 1'b0;
    logic [CH_W-1:0] chan_idx = '0;
    logic [RES_W-1:0] analog = '0;
    logic cmp_in;
    logic [RES_W-1:0] dac_code, result;
    logic hold, prech_n, busy, done;
    logic [CH_N-1:0] chan_sel;

    int checks = 0, errors = 0;
    int done_cnt = 0, prech_cnt = 0, mid_err = 0, hold_err = 0;
    logic prech_prev = 1'b1;

    always #4 clk = ~clk;
    assign cmp_in = (analog >= dac_code);

    sar_conv_ctrl #(.RES_W(RES_W), .CH_N(CH_N), .SAMPLE_CYC(SAMPLE_CYC),
        .PRE_CYC(PRE_CYC), .SETTLE_CYC(SETTLE_CYC), .LATCH_CYC(LATCH_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .chan_idx(chan_idx), .cmp_in(cmp_in), .dac_code(dac_code), .hold(hold),
        .prech_n(prech_n), .chan_sel(chan_sel), .busy(busy), .result(result),
        .done(done));

    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (prech_prev && !prech_n) prech_cnt++;
            if (!hold && dac_code != 10'h200) mid_err++;
            if (!prech_n && !hold) hold_err++;
        end
        prech_prev = prech_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !hold && prech_n && !done, "R1 ctl", {busy, hold, prech_n, done}, 4'b0010);
        chk(result == 0 && chan_sel == 0, "R1 result/chan", result, 0);
        chk(dac_code == 10'h200, "R1 dac", dac_code, 10'h200);
    endtask

    task automatic t_dummy();
        int d0;
        d0 = done_cnt; prech_cnt = 0; analog = 10'h155;
        enable = 1'b1;
        @(negedge clk);
        chk(busy, "R5 dummy starts without start", busy, 1);
        wait_idle();
        chk(done_cnt == d0, "R5 dummy no done", done_cnt - d0, 0);
        chk(result == 0, "R5 dummy result unchanged", result, 0);
        chk(prech_cnt == RES_W, "R3 dummy comparisons", prech_cnt, RES_W);
    endtask

    task automatic t_convert(input logic [RES_W-1:0] val, input logic [CH_W-1:0] ch);
        int n;
        bit got;
        int d0;
        d0 = done_cnt; prech_cnt = 0; analog = val; chan_idx = ch;
        got = 0;
        start = 1'b1;
        n = 0;
        for (int i = 1; i < 200; i++) begin
            @(posedge clk);
            @(negedge clk);
            n = i;
            if (i == 1) begin
                start = 1'b0;
                chk(chan_sel == (8'h01 << ch), "R6 one-hot channel", chan_sel, 8'h01 << ch);
            end
            if (done) begin got = 1; break; end
        end
        chk(got && n == LAT, "R10 latency", n, LAT);
        chk(result == val, "R4 result", result, val);
        chk(prech_cnt == RES_W, "R3 precharge count", prech_cnt, RES_W);
        @(negedge clk);
        chk(!done && done_cnt == d0 + 1, "R9 one-cycle done", done_cnt - d0, 1);
        chk(mid_err == 0, "R2 mid while tracking", mid_err, 0);
        chk(hold_err == 0, "R3 hold during precharge", hold_err, 0);
    endtask

    task automatic t_busy_start();
        int d0;
        d0 = done_cnt; analog = 10'h2AA;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_idle();
        repeat (5) @(negedge clk);
        chk(!busy && done_cnt == d0 + 1, "R7 start while busy ignored", done_cnt - d0, 1);
        chk(result == 10'h2AA, "R7 result", result, 10'h2AA);
    endtask

    task automatic t_disable();
        int d0;
        logic [RES_W-1:0] r0;
        d0 = done_cnt; r0 = result; analog = 10'h0F0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (15) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(!busy && !hold, "R8 idle after disable", busy, 0);
        repeat (40) @(negedge clk);
        chk(done_cnt == d0 && result == r0, "R8 no done, result kept", result, r0);
        enable = 1'b1;
        @(negedge clk);
        chk(busy, "R8 re-enable rearms dummy", busy, 1);
        wait_idle();
        chk(done_cnt == d0 && result == r0, "R8 re-armed dummy silent", done_cnt - d0, 0);
    endtask

    task automatic t_back_to_back();
        int seen;
        seen = 0; analog = 10'h123; chan_idx = 3'd3;
        start = 1'b1;
        for (int i = 0; i < 200 && seen < 2; i++) begin
            @(negedge clk);
            if (done) begin
                seen++;
                chk(result == analog, "R9 chained result", result, analog);
                chk(!busy, "R9 idle in done cycle", busy, 0);
                analog = 10'h143;
                @(negedge clk);
                chk(busy && chan_sel == 8'h08, "R9 start accepted in done cycle", chan_sel, 8'h08);
            end
        end
        start = 1'b0;
        wait_idle();
        chk(seen == 2, "R9 chained conversions", seen, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_dummy();
        t_convert(10'h000, 3'd0);
        t_convert(10'h3FF, 3'd7);
        t_convert(10'h200, 3'd3);
        t_convert(10'h1FF, 3'd5);
        t_convert(10'h123, 3'd1);
        t_busy_start();
        t_disable();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule